// File: doc/BRIEF.md
# Warp Divergence Mask Controller

This block keeps the shared program counter and the per-thread active mask of one 32-thread warp. An issue stage executes the instruction at `pc` under `active_mask`, and it pulses `step` with a short opcode for that instruction. The opcode says whether the instruction falls through, is a conditional branch, or is a backward loop branch. For a branch the issue stage also supplies the per-thread predicate, the target address and the join address where both sides meet again.

When a branch splits the active threads, the taken side runs first under its own mask. The threads that did not take the branch are parked on a small stack of divergence entries. When the taken side arrives at the join address, the parked side runs from the fall-through address. When that side arrives at the join address as well, the mask that was active before the branch comes back. A loop branch parks threads that leave the loop early, and it gathers every later leaver into the same entry. The warp moves past the loop only when no thread is still looping. Each nesting level has to join at an address of its own.

Top module: `simt_mask_ctrl`

## Requirements
- R1: After reset `pc` is 0, `active_mask` is all ones, `depth` is 0 and `overflow` is 0.
- R2: With `op` 0 (or 3) and `step` high, `pc` advances by one and the mask is kept. With `step` low, nothing changes.
- R3: A branch (`op` 1) whose predicate ANDed with the mask equals the mask goes to `target`. If that AND is zero, it goes to `pc`+1. In both cases the mask and `depth` are unchanged.
- R4: A divergent branch goes to `target` with mask `pred & active_mask` and raises `depth` by one.
- R5: When the taken side steps onto the join address, `pc` becomes the branch address plus one and the mask becomes the untaken threads. `depth` is unchanged.
- R6: When the untaken side steps onto the join address, `pc` equals the join address, the mask from before the branch is restored, and `depth` drops by one.
- R7: If the fall-through address equals the join address, the taken side arriving there restores the pre-branch mask at once and pops the entry.
- R8: A loop branch (`op` 2) with some threads continuing goes to `target` with only the continuing threads active. Leavers from later iterations join the existing entry, so `depth` does not grow.
- R9: When no active thread continues a loop, the warp goes to the loop branch address plus one with every thread that entered the loop active again, and the entry is popped.
- R10: A divergent push when `depth` is 8 sets `overflow`, which stays set until reset. `depth` stays at 8 and execution follows the taken threads.
- R11: Nested divergence restores the inner pre-branch mask at the inner join and the outer one at the outer join.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Instruction at `pc` has been issued |
| op | input | 2 | 0/3 fall-through, 1 branch, 2 loop branch |
| pred | input | 32 | Per-thread branch or loop-continue predicate |
| target | input | 16 | Taken / loop-head address |
| join_pc | input | 16 | Join address of a branch |
| pc | output | 16 | Shared program counter |
| active_mask | output | 32 | Threads enabled for the instruction at `pc` |
| depth | output | 4 | Divergence entries in use |
| overflow | output | 1 | Sticky stack overflow flag |

## Verification
Every result is registered, so `pc`, `active_mask`, `depth` and `overflow` take their new values at the same rising edge that samples `step`. Nothing is delayed by more than that one edge. The bench drives each step on the falling edge and compares all outputs one time unit after the next rising edge. Each comparison therefore sees exactly one step's effect. This includes the join steps, where a switch of side or a pop takes place in that same edge.

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl #(
  parameter int WARP  = 32,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [1:0]      op,
  input  logic [WARP-1:0] pred,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] join_pc,
  output logic [PC_W-1:0] pc,
  output logic [WARP-1:0] active_mask,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic            overflow
);
  localparam int DW = $clog2(DEPTH+1);
  localparam int AW = $clog2(DEPTH);

  typedef struct packed {
    logic [PC_W-1:0] rpc;
    logic [PC_W-1:0] ppc;
    logic [WARP-1:0] pmask;
    logic            els;
  } ent_t;

  ent_t stk [DEPTH];
  ent_t top;
  logic [PC_W-1:0] npc;
  logic [WARP-1:0] nmask;

  wire [PC_W-1:0] pc1   = pc + 1'b1;
  wire [WARP-1:0] tk    = pred & active_mask;
  wire [WARP-1:0] nt    = ~pred & active_mask;
  wire            is_br = op == 2'd1;
  wire            is_lp = op == 2'd2;
  wire            split = (tk != '0) && (nt != '0);
  wire            empty = depth == '0;
  wire            full  = depth == DW'(DEPTH);
  wire [AW-1:0]   ti    = AW'(depth - 1'b1);
  wire [AW-1:0]   wi    = AW'(depth);

  assign top = empty ? '0 : stk[ti];

  wire merge  = is_lp && split && !empty && !top.els && top.rpc == pc1 && top.ppc == pc1;
  wire push   = (is_br || is_lp) && split && !merge;
  wire rejoin = !push && !merge && !empty && npc == top.rpc;

  always_comb begin
    npc   = pc1;
    nmask = active_mask;
    if (is_br) begin
      if (tk != '0) npc = target;
      if (split)    nmask = tk;
    end else if (is_lp && tk != '0) begin
      npc   = target;
      nmask = tk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc          <= '0;
      active_mask <= '1;
      depth       <= '0;
      overflow    <= 1'b0;
    end else if (step) begin
      if (merge) begin
        stk[ti].pmask <= top.pmask | nt;
        pc            <= npc;
        active_mask   <= nmask;
      end else if (push) begin
        if (full) overflow <= 1'b1;
        else begin
          stk[wi] <= '{rpc: is_br ? join_pc : pc1, ppc: pc1, pmask: nt, els: 1'b0};
          depth   <= depth + 1'b1;
        end
        pc          <= npc;
        active_mask <= nmask;
      end else if (rejoin) begin
        if (!top.els && top.ppc != top.rpc) begin
          pc            <= top.ppc;
          active_mask   <= top.pmask;
          stk[ti].pmask <= top.pmask | nmask;
          stk[ti].els   <= 1'b1;
        end else begin
          pc          <= top.rpc;
          active_mask <= top.els ? top.pmask : (top.pmask | nmask);
          depth       <= depth - 1'b1;
        end
      end else begin
        pc          <= npc;
        active_mask <= nmask;
      end
    end
  end
endmodule

module simt_mask_ctrl_chk #(
  parameter int WARP  = 32,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step,
  input logic [1:0]      op,
  input logic [WARP-1:0] pred,
  input logic [PC_W-1:0] target,
  input logic [PC_W-1:0] pc,
  input logic [WARP-1:0] active_mask,
  input logic [$clog2(DEPTH+1)-1:0] depth,
  input logic            overflow
);
  wire [WARP-1:0] tk = pred & active_mask;
  wire [WARP-1:0] nt = ~pred & active_mask;

  assert_mask_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask != '0);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc) && $stable(active_mask) && $stable(depth));

  assert_uniform_no_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step && op == 2'd1 && (tk == '0 || nt == '0) |=> depth <= $past(depth));

  assert_split_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step && op == 2'd1 && tk != '0 && nt != '0 && depth < DEPTH
    |=> depth == $past(depth) + 1'b1 && active_mask == $past(tk) && pc == $past(target));

  assert_loop_continue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step && op == 2'd2 && tk != '0 |=> active_mask == $past(tk) && pc == $past(target));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DEPTH);
endmodule

bind simt_mask_ctrl simt_mask_ctrl_chk #(.WARP(WARP), .PC_W(PC_W), .DEPTH(DEPTH)) chk (
  .clk(clk), .rst_n(rst_n), .step(step), .op(op), .pred(pred), .target(target),
  .pc(pc), .active_mask(active_mask), .depth(depth), .overflow(overflow));

// File: tb/simt_mask_ctrl_test.sv
module simt_mask_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        step = 0;
  logic [1:0]  op = 0;
  logic [31:0] pred = 0;
  logic [15:0] target = 0, join_pc = 0;
  logic [15:0] pc;
  logic [31:0] active_mask;
  logic [3:0]  depth;
  logic        overflow;
  int checks = 0, errors = 0;

  simt_mask_ctrl uut (.clk(clk), .rst_n(rst_n), .step(step), .op(op), .pred(pred),
    .target(target), .join_pc(join_pc), .pc(pc), .active_mask(active_mask),
    .depth(depth), .overflow(overflow));

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic state(string tag, int epc, logic [31:0] emask, int ed);
    chk({tag, " pc"}, 32'(pc), 32'(epc));
    chk({tag, " mask"}, active_mask, emask);
    chk({tag, " depth"}, 32'(depth), 32'(ed));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; step = 0;
    @(posedge clk); #1;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic drive(logic [1:0] o, logic [31:0] p, int t, int j);
    @(negedge clk);
    step = 1; op = o; pred = p; target = 16'(t); join_pc = 16'(j);
    @(posedge clk); #1;
    step = 0;
  endtask

  task automatic seq(int n);
    for (int i = 0; i < n; i++) drive(2'd0, 32'h0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    state("R1 reset", 0, 32'hFFFF_FFFF, 0);
    chk("R1 overflow", 32'(overflow), 0);

    seq(3);
    state("R2 advance", 3, 32'hFFFF_FFFF, 0);
    repeat (3) @(posedge clk);
    #1 state("R2 idle", 3, 32'hFFFF_FFFF, 0);
    drive(2'd3, 32'hFFFF_FFFF, 40, 0);
    chk("R2 op3", 32'(pc), 4);

    do_reset();
    drive(2'd1, 32'hFFFF_FFFF, 9, 12);
    state("R3 all taken", 9, 32'hFFFF_FFFF, 0);
    drive(2'd1, 32'h0, 2, 12);
    state("R3 none taken", 10, 32'hFFFF_FFFF, 0);

    for (int k = 0; k < 16; k++) begin
      logic [31:0] p;
      p = 32'(k + 1) * 32'h0101_0103;
      do_reset();
      drive(2'd1, p, 3, 5);
      state("R4 split", 3, p, 1);
      seq(1);
      seq(1);
      state("R5 else side", 1, ~p, 1);
      seq(3);
      chk("R5 else walk", 32'(pc), 4);
      seq(1);
      state("R6 restore", 5, 32'hFFFF_FFFF, 0);
    end

    do_reset();
    drive(2'd1, 32'h0F0F_0F0F, 6, 1);
    state("R7 then", 6, 32'h0F0F_0F0F, 1);
    drive(2'd1, 32'hFF0F_0F0F, 1, 0);
    state("R7 join", 1, 32'hFFFF_FFFF, 0);

    for (int m = 2; m <= 6; m++) begin
      do_reset();
      seq(1);
      for (int it = 0; it < m; it++) begin
        logic [31:0] cont;
        cont = 0;
        for (int i = 0; i < 32; i++) if ((i % m) + 1 > it + 1) cont[i] = 1'b1;
        seq(1);
        drive(2'd2, cont, 1, 0);
        if (cont != 0) state("R8 loop iter", 1, cont, 1);
        else           state("R9 loop exit", 3, 32'hFFFF_FFFF, 0);
      end
    end

    do_reset();
    drive(2'd1, 32'h0000_FFFF, 10, 20);
    state("R11 outer then", 10, 32'h0000_FFFF, 1);
    drive(2'd1, 32'h0000_00FF, 15, 18);
    state("R11 inner then", 15, 32'h0000_00FF, 2);
    seq(3);
    state("R11 inner else", 11, 32'h0000_FF00, 2);
    seq(6);
    seq(1);
    state("R11 inner join", 18, 32'h0000_FFFF, 1);
    seq(2);
    state("R11 outer else", 1, 32'hFFFF_0000, 1);
    seq(18);
    seq(1);
    state("R11 outer join", 20, 32'hFFFF_FFFF, 0);

    do_reset();
    for (int k = 0; k < 9; k++) begin
      logic [31:0] p;
      p = 32'hFFFF_FFFF << (k + 1);
      drive(2'd1, p, 2 * (k + 1), 100 + k);
      state("R10 push", 2 * (k + 1), p, (k < 8) ? k + 1 : 8);
      chk("R10 flag", 32'(overflow), (k == 8) ? 1 : 0);
    end
    seq(1);
    chk("R10 sticky", 32'(overflow), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule